// File: doc/BRIEF.md
# DMA Channel Register Bank

This block holds the software-visible registers of one DMA channel and one register shared by all channels. Software reaches them over a simple peripheral bus with a request, a write flag, a size code, an address and write data. The block answers with read data and a ready pulse. A transfer engine reads the stored source address, destination address, transfer count and control word from dedicated outputs. It drives single-cycle pulses to step the addresses, count down the transfer count and raise status flags.

The status flags follow a two-step clearing rule that keeps a late hardware event from being lost. A flag clears only when software first reads it as 1 and then writes 0 to it. Writing 1 never sets a flag. Each access takes a fixed number of bus cycles that depends on its size. A malformed access is refused: it reports an access error, returns zero and changes nothing.

Top module: `dma_chan_regs`

## Requirements
- R1: Byte offsets select the registers: 0x00 source address, 0x04 destination address, 0x08 transfer count, 0x0C channel control, 0x10 shared operation register.
- R2: Size codes are 0 for byte, 1 for half, 2 for word. Source, destination and control accept half or word access. A half access uses busAddr[1] to pick the half (0 low, 1 high). It carries its data on bits 15:0 of the data buses, and a half write keeps the other half unchanged.
- R3: The transfer count accepts word access only. It stores write bits 23:0, ignores bits 31:24, and those bits read as 0.
- R4: Control bit 1 is the done flag. A write of 0 to it clears the flag only if a read returned it as 1 since the last write to the control register. Writing 1 never sets it, and any write to the control register cancels an earlier read.
- R5: The shared register is 16 bits wide and takes half access at 0x10 or byte access at 0x10 (bits 7:0) or 0x11 (bits 15:8), with byte data on bits 7:0. Its bit 1 (abort) and bit 2 (error) clear under the rule of R4. Only a read that covers bits 7:0 arms a clear, and any write to the register cancels the arming.
- R6: Any other access is refused. This covers a byte access to a channel register, a half access to the count, a word access to the shared register, a misaligned address, an unmapped offset and size code 3. A refused access returns 0, changes no register and asserts accessErr together with busReady.
- R7: busReady is high for one cycle. For a byte or half access this is the 3rd cycle of busReq high, and for a word access the 6th, counting the first cycle busReq is seen high while the block is idle. A write takes effect at the clock edge that ends the ready cycle.
- R8: After reset the control register and the shared register read 0.
- R9: An engSrcInc or engDstInc pulse adds a step to the source or destination address. The step comes from control bits 3:2: 0 gives 1, 1 gives 2, 2 or 3 give 4. A later read returns the advanced address.
- R10: An engCntDec pulse lowers a nonzero count by 1. At a count of 0 the count stays 0 and the done flag is set.
- R11: A hardware set of a flag in the same cycle as a software clear of it leaves the flag at 1.
- R12: srcAddr, dstAddr, xferCount, chanCtrl and opReg always show the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Access request, held until busReady |
| busWr | input | 1 | 1 for write, 0 for read |
| busSize | input | 2 | Access size code |
| busAddr | input | 5 | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | Access-complete pulse |
| accessErr | output | 1 | Refused-access pulse, with busReady |
| engSrcInc | input | 1 | Advance source address |
| engDstInc | input | 1 | Advance destination address |
| engCntDec | input | 1 | Decrement transfer count |
| engDoneSet | input | 1 | Set done flag |
| engErrSet | input | 1 | Set shared error flag |
| engAbortSet | input | 1 | Set shared abort flag |
| srcAddr | output | 32 | Current source address |
| dstAddr | output | 32 | Current destination address |
| xferCount | output | 24 | Current transfer count |
| chanCtrl | output | 32 | Current control word |
| opReg | output | 16 | Current shared register |

## Verification
A stuck or wrongly set read-arm bit shows up on the next write of 0 to a flag. The flag either drops without a prior read or survives after one, and chanCtrl or opReg shows this one cycle after the ready pulse. A wrong decode or lane merge shows up on the next read-back of the touched register, and a half-write error appears only in the half not addressed. Step and count faults appear on the engine-facing outputs in the cycle after the pulse. Timing faults move busReady away from the 3rd or 6th cycle of the request.

// File: rtl/dmaregs_pkg.sv
package dmaregs_pkg;
  localparam int REG_W  = 32;
  localparam int HALF_W = 16;
  localparam int OP_W   = 16;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam int DONE_BIT = 1;

  typedef enum logic [2:0] {
    SEL_SRC, SEL_DST, SEL_CNT, SEL_CTL, SEL_OPR, SEL_NONE
  } regSel_e;

  typedef enum logic [1:0] {
    LANE_ALL, LANE_LO, LANE_HI
  } lane_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrEn;
    logic    rdEn;
    regSel_e sel;
    lane_e   lane;
  } strobe_t;
endpackage

// File: rtl/dmaregs_ctrl.sv
module dmaregs_ctrl
  import dmaregs_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int WORD_CYC = 3,
  parameter int LONG_CYC = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWr,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic [REG_W-1:0]  rdBack,
  output logic [REG_W-1:0]  busRdata,
  output logic              busReady,
  output logic              accessErr,
  output strobe_t           strb,
  output logic [REG_W-1:0]  wdLatched
);
  localparam int CNT_W = $clog2(LONG_CYC);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(WORD_CYC - 2);
  localparam logic [CNT_W-1:0] LAST_LONG = CNT_W'(LONG_CYC - 2);
  localparam logic [IDX_W-1:0] IDX_SRC = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_DST = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_CNT = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_CTL = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_OPR = IDX_W'(4);

  logic             busy, wrQ, okQ;
  logic [CNT_W-1:0] cycCnt, lastQ;
  regSel_e          selQ, selD;
  lane_e            laneQ, laneD;
  logic             okD;
  logic [IDX_W-1:0] wordIdx;

  assign wordIdx = busAddr[ADDR_W-1:2];

  // decode of size and offset into register select and lane
  always_comb begin
    selD  = SEL_NONE;
    laneD = LANE_ALL;
    okD   = 1'b0;
    unique case (busSize)
      SZ_WORD: if (busAddr[1:0] == 2'b00) begin
        okD = 1'b1;
        case (wordIdx)
          IDX_SRC: selD = SEL_SRC;
          IDX_DST: selD = SEL_DST;
          IDX_CNT: selD = SEL_CNT;
          IDX_CTL: selD = SEL_CTL;
          default: okD = 1'b0;
        endcase
      end
      SZ_HALF: if (!busAddr[0]) begin
        laneD = busAddr[1] ? LANE_HI : LANE_LO;
        okD   = 1'b1;
        case (wordIdx)
          IDX_SRC: selD = SEL_SRC;
          IDX_DST: selD = SEL_DST;
          IDX_CTL: selD = SEL_CTL;
          IDX_OPR: begin
            selD  = SEL_OPR;
            laneD = LANE_ALL;
            okD   = !busAddr[1];
          end
          default: okD = 1'b0;
        endcase
      end
      SZ_BYTE: if (wordIdx == IDX_OPR && !busAddr[1]) begin
        selD  = SEL_OPR;
        laneD = busAddr[0] ? LANE_HI : LANE_LO;
        okD   = 1'b1;
      end
      default: okD = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      cycCnt    <= '0;
      lastQ     <= '0;
      wrQ       <= 1'b0;
      okQ       <= 1'b0;
      selQ      <= SEL_NONE;
      laneQ     <= LANE_ALL;
      wdLatched <= '0;
    end else if (!busy) begin
      if (busReq) begin
        busy      <= 1'b1;
        cycCnt    <= '0;
        lastQ     <= (busSize == SZ_WORD) ? LAST_LONG : LAST_WORD;
        wrQ       <= busWr;
        okQ       <= okD;
        selQ      <= okD ? selD : SEL_NONE;
        laneQ     <= laneD;
        wdLatched <= busWdata;
      end
    end else if (busReady) begin
      busy <= 1'b0;
    end else begin
      cycCnt <= cycCnt + 1'b1;
    end
  end

  assign busReady  = busy && (cycCnt == lastQ);
  assign accessErr = busReady && !okQ;
  assign strb.wrEn = busReady && okQ && wrQ;
  assign strb.rdEn = busReady && okQ && !wrQ;
  assign strb.sel  = selQ;
  assign strb.lane = laneQ;
  assign busRdata  = strb.rdEn ? rdBack : '0;
endmodule

// File: rtl/dmaregs_dp.sv
module dmaregs_dp
  import dmaregs_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [REG_W-1:0]  wd,
  input  logic              engSrcInc,
  input  logic              engDstInc,
  input  logic              engCntDec,
  input  logic              engDoneSet,
  input  logic              engErrSet,
  input  logic              engAbortSet,
  output logic [REG_W-1:0]  rdBack,
  output logic [REG_W-1:0]  srcAddr,
  output logic [REG_W-1:0]  dstAddr,
  output logic [CNT_W-1:0]  xferCount,
  output logic [REG_W-1:0]  chanCtrl,
  output logic [OP_W-1:0]   opReg
);
  localparam int NUM_ADDR = 2;
  localparam int NUM_FLAG = 2;
  localparam int FLAG_LSB = 1;

  function automatic logic [REG_W-1:0] mergeHalf(logic [REG_W-1:0] old,
                                                 logic [REG_W-1:0] nw, lane_e ln);
    case (ln)
      LANE_LO: mergeHalf = {old[REG_W-1:HALF_W], nw[HALF_W-1:0]};
      LANE_HI: mergeHalf = {nw[HALF_W-1:0], old[HALF_W-1:0]};
      default: mergeHalf = nw;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] readHalf(logic [REG_W-1:0] v, lane_e ln);
    case (ln)
      LANE_LO: readHalf = {{HALF_W{1'b0}}, v[HALF_W-1:0]};
      LANE_HI: readHalf = {{HALF_W{1'b0}}, v[REG_W-1:HALF_W]};
      default: readHalf = v;
    endcase
  endfunction

  logic [REG_W-1:0] addrQ [NUM_ADDR];
  logic [CNT_W-1:0] cntQ;
  logic [REG_W-1:0] ctlQ, ctlNext;
  logic [OP_W-1:0]  opQ, opMerged, opNext;
  logic [REG_W-1:0] step;
  logic             doneArm, doneNext, cntHitZero;
  logic             ctlWr, ctlRd, opWr, opRd, coversLow;
  logic [NUM_FLAG-1:0] flagNext, flagHw;

  assign coversLow = (strb.lane != LANE_HI);
  assign ctlWr = strb.wrEn && strb.sel == SEL_CTL;
  assign ctlRd = strb.rdEn && strb.sel == SEL_CTL;
  assign opWr  = strb.wrEn && strb.sel == SEL_OPR;
  assign opRd  = strb.rdEn && strb.sel == SEL_OPR;

  always_comb begin
    case (ctlQ[3:2])
      2'd0:    step = REG_W'(1);
      2'd1:    step = REG_W'(2);
      default: step = REG_W'(4);
    endcase
  end

  // source and destination address counters
  generate
    for (genvar g = 0; g < NUM_ADDR; g++) begin : gAddr
      localparam regSel_e MY_SEL = (g == 0) ? SEL_SRC : SEL_DST;
      logic incPulse;
      assign incPulse = (g == 0) ? engSrcInc : engDstInc;
      always_ff @(posedge clk) begin
        if (strb.wrEn && strb.sel == MY_SEL)
          addrQ[g] <= mergeHalf(addrQ[g], wd, strb.lane);
        else if (incPulse)
          addrQ[g] <= addrQ[g] + step;
      end
    end
  endgenerate

  // transfer count
  assign cntHitZero = engCntDec && (cntQ == '0);
  always_ff @(posedge clk) begin
    if (strb.wrEn && strb.sel == SEL_CNT)
      cntQ <= wd[CNT_W-1:0];
    else if (engCntDec && cntQ != '0)
      cntQ <= cntQ - 1'b1;
  end

  // control word and done flag
  always_comb begin
    doneNext = ctlQ[DONE_BIT];
    if (ctlWr && coversLow && !wd[DONE_BIT] && doneArm) doneNext = 1'b0;
    if (engDoneSet || cntHitZero) doneNext = 1'b1;
    ctlNext = ctlWr ? mergeHalf(ctlQ, wd, strb.lane) : ctlQ;
    ctlNext[DONE_BIT] = doneNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ    <= '0;
      doneArm <= 1'b0;
    end else begin
      ctlQ <= ctlNext;
      if (ctlWr)                              doneArm <= 1'b0;
      else if (ctlRd && coversLow && ctlQ[DONE_BIT]) doneArm <= 1'b1;
    end
  end

  // shared operation register with two clearable flags
  assign flagHw = {engErrSet, engAbortSet};

  always_comb begin
    case (strb.lane)
      LANE_LO: opMerged = {opQ[OP_W-1:8], wd[7:0]};
      LANE_HI: opMerged = {wd[7:0], opQ[7:0]};
      default: opMerged = wd[OP_W-1:0];
    endcase
  end

  generate
    for (genvar f = 0; f < NUM_FLAG; f++) begin : gFlag
      localparam int BITPOS = FLAG_LSB + f;
      logic arm, nxt;
      always_comb begin
        nxt = opQ[BITPOS];
        if (opWr && coversLow && !wd[BITPOS] && arm) nxt = 1'b0;
        if (flagHw[f]) nxt = 1'b1;
      end
      assign flagNext[f] = nxt;
      always_ff @(posedge clk) begin
        if (!rstN)                                   arm <= 1'b0;
        else if (opWr)                               arm <= 1'b0;
        else if (opRd && coversLow && opQ[BITPOS])   arm <= 1'b1;
      end
    end
  endgenerate

  always_comb begin
    opNext = opWr ? opMerged : opQ;
    opNext[FLAG_LSB +: NUM_FLAG] = flagNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) opQ <= '0;
    else       opQ <= opNext;
  end

  // read-back mux
  always_comb begin
    case (strb.sel)
      SEL_SRC: rdBack = readHalf(addrQ[0], strb.lane);
      SEL_DST: rdBack = readHalf(addrQ[1], strb.lane);
      SEL_CNT: rdBack = {{(REG_W-CNT_W){1'b0}}, cntQ};
      SEL_CTL: rdBack = readHalf(ctlQ, strb.lane);
      SEL_OPR: begin
        case (strb.lane)
          LANE_LO: rdBack = {{(REG_W-8){1'b0}}, opQ[7:0]};
          LANE_HI: rdBack = {{(REG_W-8){1'b0}}, opQ[OP_W-1:8]};
          default: rdBack = {{(REG_W-OP_W){1'b0}}, opQ};
        endcase
      end
      default: rdBack = '0;
    endcase
  end

  assign srcAddr   = addrQ[0];
  assign dstAddr   = addrQ[1];
  assign xferCount = cntQ;
  assign chanCtrl  = ctlQ;
  assign opReg     = opQ;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmaregs_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 24,
  parameter int WORD_CYC = 3,
  parameter int LONG_CYC = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWr,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busReady,
  output logic              accessErr,
  input  logic              engSrcInc,
  input  logic              engDstInc,
  input  logic              engCntDec,
  input  logic              engDoneSet,
  input  logic              engErrSet,
  input  logic              engAbortSet,
  output logic [31:0]       srcAddr,
  output logic [31:0]       dstAddr,
  output logic [CNT_W-1:0]  xferCount,
  output logic [31:0]       chanCtrl,
  output logic [15:0]       opReg
);
  strobe_t          strb;
  logic [REG_W-1:0] wdLatched, rdBack;

  dmaregs_ctrl #(.ADDR_W(ADDR_W), .WORD_CYC(WORD_CYC), .LONG_CYC(LONG_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr), .busSize(busSize),
    .busAddr(busAddr), .busWdata(busWdata), .rdBack(rdBack), .busRdata(busRdata),
    .busReady(busReady), .accessErr(accessErr), .strb(strb), .wdLatched(wdLatched)
  );

  dmaregs_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wd(wdLatched),
    .engSrcInc(engSrcInc), .engDstInc(engDstInc), .engCntDec(engCntDec),
    .engDoneSet(engDoneSet), .engErrSet(engErrSet), .engAbortSet(engAbortSet),
    .rdBack(rdBack), .srcAddr(srcAddr), .dstAddr(dstAddr), .xferCount(xferCount),
    .chanCtrl(chanCtrl), .opReg(opReg)
  );
endmodule

// File: rtl/dmaregs_chk.sv
module dmaregs_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWr,
  input logic [31:0]      busRdata,
  input logic             busReady,
  input logic             accessErr,
  input logic             engSrcInc,
  input logic             engDstInc,
  input logic             engCntDec,
  input logic             engDoneSet,
  input logic             engErrSet,
  input logic             engAbortSet,
  input logic [31:0]      srcAddr,
  input logic [31:0]      dstAddr,
  input logic [CNT_W-1:0] xferCount,
  input logic [31:0]      chanCtrl,
  input logic [15:0]      opReg
);
  logic engIdle;
  assign engIdle = !(engSrcInc || engDstInc || engCntDec || engDoneSet || engErrSet || engAbortSet);

  a_r7_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady);

  a_r6_err_with_ready: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> (busReady && busRdata == 32'd0));

  a_r6_err_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (accessErr && engIdle) |=> ($stable(srcAddr) && $stable(dstAddr) &&
      $stable(xferCount) && $stable(chanCtrl) && $stable(opReg)));

  a_r4_done_falls_on_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chanCtrl[1]) |-> $past(busReady && busWr && !accessErr));

  a_r11_done_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    engDoneSet |=> chanCtrl[1]);

  a_r10_zero_count_sets_done: assert property (@(posedge clk) disable iff (!rstN)
    (engCntDec && xferCount == '0 && !busReady) |=> (chanCtrl[1] && xferCount == '0));

  a_r5_shared_flags_set: assert property (@(posedge clk) disable iff (!rstN)
    (engErrSet && engAbortSet) |=> (opReg[2] && opReg[1]));
endmodule

bind dma_chan_regs dmaregs_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWr = 1'b0;
  logic [1:0]  busSize = 2'd0;
  logic [4:0]  busAddr = 5'd0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic        busReady, accessErr;
  logic [5:0]  engVec = 6'd0; // {abort, err, done, dec, dst, src}
  logic        engDoneExtra = 1'b0;
  logic [31:0] srcAddr, dstAddr, chanCtrl;
  logic [23:0] xferCount;
  logic [15:0] opReg;
  int tests = 0, fails = 0;

  always #4 clk = ~clk; // 125 MHz

  dma_chan_regs u_dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr), .busSize(busSize),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .accessErr(accessErr), .engSrcInc(engVec[0]), .engDstInc(engVec[1]),
    .engCntDec(engVec[2]), .engDoneSet(engVec[3] | engDoneExtra), .engErrSet(engVec[4]),
    .engAbortSet(engVec[5]), .srcAddr(srcAddr), .dstAddr(dstAddr), .xferCount(xferCount),
    .chanCtrl(chanCtrl), .opReg(opReg)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [4:0]  ad;
    logic [31:0] wd;
    logic [31:0] ex;
    logic        er;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 5'h0C, 32'h0,        32'h0,        1'b0, 8'd8},  // R8 control reset
    '{1'b0, 2'd1, 5'h10, 32'h0,        32'h0,        1'b0, 8'd8},  // R8 shared reset
    '{1'b1, 2'd2, 5'h00, 32'h12345678, 32'h0,        1'b0, 8'd1},  // R1
    '{1'b0, 2'd2, 5'h00, 32'h0,        32'h12345678, 1'b0, 8'd1},  // R1
    '{1'b1, 2'd1, 5'h02, 32'h0000ABCD, 32'h0,        1'b0, 8'd2},  // R2 high half
    '{1'b0, 2'd2, 5'h00, 32'h0,        32'hABCD5678, 1'b0, 8'd2},  // R2
    '{1'b0, 2'd1, 5'h00, 32'h0,        32'h00005678, 1'b0, 8'd2},  // R2 low half read
    '{1'b1, 2'd2, 5'h04, 32'hCAFE0000, 32'h0,        1'b0, 8'd1},  // R1
    '{1'b1, 2'd1, 5'h04, 32'h0000BEEF, 32'h0,        1'b0, 8'd2},  // R2 low half
    '{1'b0, 2'd2, 5'h04, 32'h0,        32'hCAFEBEEF, 1'b0, 8'd2},  // R2
    '{1'b1, 2'd2, 5'h08, 32'hFF123456, 32'h0,        1'b0, 8'd3},  // R3
    '{1'b0, 2'd2, 5'h08, 32'h0,        32'h00123456, 1'b0, 8'd3},  // R3 upper reads 0
    '{1'b1, 2'd1, 5'h08, 32'h00001111, 32'h0,        1'b1, 8'd6},  // R6 half to count
    '{1'b0, 2'd2, 5'h08, 32'h0,        32'h00123456, 1'b0, 8'd6},  // R6 unchanged
    '{1'b1, 2'd2, 5'h10, 32'hFFFFFFFF, 32'h0,        1'b1, 8'd6},  // R6 word to shared
    '{1'b0, 2'd1, 5'h10, 32'h0,        32'h0,        1'b0, 8'd6},  // R6 unchanged
    '{1'b1, 2'd0, 5'h11, 32'h0000005A, 32'h0,        1'b0, 8'd5},  // R5 high byte
    '{1'b0, 2'd1, 5'h10, 32'h0,        32'h00005A00, 1'b0, 8'd5},  // R5
    '{1'b0, 2'd0, 5'h11, 32'h0,        32'h0000005A, 1'b0, 8'd5},  // R5 byte read
    '{1'b0, 2'd2, 5'h14, 32'h0,        32'h0,        1'b1, 8'd6},  // R6 unmapped
    '{1'b0, 2'd0, 5'h0C, 32'h0,        32'h0,        1'b1, 8'd6},  // R6 byte to control
    '{1'b1, 2'd2, 5'h0C, 32'hFFFF0F0F, 32'h0,        1'b0, 8'd4},  // R4 write 1 to flag
    '{1'b0, 2'd2, 5'h0C, 32'h0,        32'hFFFF0F0D, 1'b0, 8'd4},  // R4 flag stays 0
    '{1'b1, 2'd1, 5'h0E, 32'h00001234, 32'h0,        1'b0, 8'd2},  // R2 control high half
    '{1'b0, 2'd2, 5'h0C, 32'h0,        32'h12340F0D, 1'b0, 8'd2},  // R2
    '{1'b1, 2'd1, 5'h10, 32'h0,        32'h0,        1'b0, 8'd5}   // R5 restore
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busAcc(input bit wr, input logic [1:0] sz, input logic [4:0] ad,
                        input logic [31:0] wd, input bit pulseDone,
                        output logic [31:0] rd, output bit er, output int cyc);
    @(posedge clk); #1;
    busReq = 1'b1; busWr = wr; busSize = sz; busAddr = ad; busWdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!busReady);
    rd = busRdata;
    er = accessErr;
    if (pulseDone) engDoneExtra = 1'b1;
    @(posedge clk); #1;
    busReq = 1'b0; engDoneExtra = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] v);
    @(posedge clk); #1; engVec = v;
    @(posedge clk); #1; engVec = 6'd0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    bit er;
    int cyc;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R8 chanCtrl", chanCtrl, 32'h0);
    check("R8 opReg", {16'h0, opReg}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      busAcc(VECS[i].wr, VECS[i].sz, VECS[i].ad, VECS[i].wd, 1'b0, rd, er, cyc);
      check($sformatf("R%0d vec %0d err", VECS[i].req, i), {31'b0, er}, {31'b0, VECS[i].er});
      if (!VECS[i].wr)
        check($sformatf("R%0d vec %0d data", VECS[i].req, i), rd, VECS[i].ex);
    end

    // R7 access durations
    busAcc(1'b0, 2'd1, 5'h00, 32'h0, 1'b0, rd, er, cyc);
    check("R7 half cycles", cyc, 3);
    busAcc(1'b0, 2'd2, 5'h00, 32'h0, 1'b0, rd, er, cyc);
    check("R7 word cycles", cyc, 6);
    busAcc(1'b0, 2'd2, 5'h18, 32'h0, 1'b0, rd, er, cyc);
    check("R7 refused word cycles", cyc, 6);

    // R9 address stepping, R12 exported values
    busAcc(1'b1, 2'd2, 5'h0C, 32'h00000008, 1'b0, rd, er, cyc);
    busAcc(1'b1, 2'd2, 5'h00, 32'h00001000, 1'b0, rd, er, cyc);
    pulse(6'b000001);
    pulse(6'b000001);
    @(negedge clk);
    check("R12 srcAddr port", srcAddr, 32'h00001008);
    busAcc(1'b0, 2'd2, 5'h00, 32'h0, 1'b0, rd, er, cyc);
    check("R9 src step 4", rd, 32'h00001008);
    busAcc(1'b1, 2'd2, 5'h0C, 32'h00000004, 1'b0, rd, er, cyc);
    busAcc(1'b1, 2'd2, 5'h04, 32'h00000200, 1'b0, rd, er, cyc);
    pulse(6'b000010);
    busAcc(1'b0, 2'd2, 5'h04, 32'h0, 1'b0, rd, er, cyc);
    check("R9 dst step 2", rd, 32'h00000202);
    busAcc(1'b1, 2'd2, 5'h0C, 32'h00000000, 1'b0, rd, er, cyc);
    pulse(6'b000010);
    @(negedge clk);
    check("R12 dstAddr port step 1", dstAddr, 32'h00000203);

    // R10 count down to zero, then hold and set done
    busAcc(1'b1, 2'd2, 5'h08, 32'h00000002, 1'b0, rd, er, cyc);
    pulse(6'b000100);
    pulse(6'b000100);
    @(negedge clk);
    check("R10 count at zero", {8'h0, xferCount}, 32'h0);
    check("R10 done still clear", {31'b0, chanCtrl[1]}, 32'h0);
    pulse(6'b000100);
    @(negedge clk);
    check("R10 count holds", {8'h0, xferCount}, 32'h0);
    check("R10 done set", {31'b0, chanCtrl[1]}, 32'h1);

    // R4 read-then-write-0 clearing
    busAcc(1'b1, 2'd2, 5'h0C, 32'h0, 1'b0, rd, er, cyc);
    @(negedge clk);
    check("R4 write 0 without read keeps flag", {31'b0, chanCtrl[1]}, 32'h1);
    busAcc(1'b0, 2'd2, 5'h0C, 32'h0, 1'b0, rd, er, cyc);
    check("R4 read shows flag", rd, 32'h00000002);
    busAcc(1'b1, 2'd2, 5'h0C, 32'h00000002, 1'b0, rd, er, cyc);
    busAcc(1'b1, 2'd2, 5'h0C, 32'h0, 1'b0, rd, er, cyc);
    @(negedge clk);
    check("R4 intervening write disarms", {31'b0, chanCtrl[1]}, 32'h1);
    busAcc(1'b0, 2'd1, 5'h0C, 32'h0, 1'b0, rd, er, cyc);
    busAcc(1'b1, 2'd1, 5'h0C, 32'h0, 1'b0, rd, er, cyc);
    @(negedge clk);
    check("R4 read then write 0 clears", {31'b0, chanCtrl[1]}, 32'h0);

    // R11 hardware set beats software clear
    pulse(6'b001000);
    busAcc(1'b0, 2'd2, 5'h0C, 32'h0, 1'b0, rd, er, cyc);
    busAcc(1'b1, 2'd2, 5'h0C, 32'h0, 1'b1, rd, er, cyc);
    @(negedge clk);
    check("R11 set wins over clear", {31'b0, chanCtrl[1]}, 32'h1);

    // R5 shared flags
    pulse(6'b110000);
    @(negedge clk);
    check("R5 flags set", {16'h0, opReg}, 32'h00000006);
    busAcc(1'b0, 2'd0, 5'h11, 32'h0, 1'b0, rd, er, cyc);
    busAcc(1'b1, 2'd0, 5'h10, 32'h0, 1'b0, rd, er, cyc);
    @(negedge clk);
    check("R5 high-byte read does not arm", {16'h0, opReg}, 32'h00000006);
    busAcc(1'b0, 2'd1, 5'h10, 32'h0, 1'b0, rd, er, cyc);
    check("R5 read flags", rd, 32'h00000006);
    busAcc(1'b1, 2'd0, 5'h10, 32'h0, 1'b0, rd, er, cyc);
    @(negedge clk);
    check("R5 flags cleared", {16'h0, opReg}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule